// File: doc/BRIEF.md
# Two-Bank Byte Register File with Pointer Indirection

This block is the data store of a small 8-bit controller core. It holds two banks of byte storage behind a 7-bit offset. Each bank has a low control region and a general-purpose region above it. Bit 5 of an on-file status register chooses which bank a direct access reaches. The status register and an 8-bit pointer register sit in the control region and reach the same physical register from either bank.

Offset 0x00 is not storage. Any access to it is redirected to the location named by the pointer: pointer bit 7 picks the bank and bits 6:0 pick the offset. A program can walk a table by stepping the pointer and then touching offset 0x00 again. When the pointer names offset 0x00 itself, in either bank, a read of it returns zero and a write to it is dropped.

Reads are registered one edge after the strobe. Writes take effect at the edge on which they are sampled. The pointer is also brought out as an output.

Top module: `bankreg_file`

## Requirements
- R1: A synchronous active-low reset clears the read data output, the pointer, the status register (which selects bank 0) and every general-purpose byte.
- R2: A direct access to offsets 0x0C through 0x4F reaches a general-purpose byte in the bank chosen by status bit 5 (0 = bank 0, 1 = bank 1). The two banks hold separate bytes at the same offset.
- R3: Offset 0x01 (pointer) and offset 0x02 (status) are the same register whichever bank is selected.
- R4: Offsets 0x03 through 0x0B and 0x50 through 0x7F read as 0x00, and writes to them change nothing.
- R5: An access to offset 0x00 goes to the bank given by pointer bit 7, at the offset given by pointer bits 6:0. This holds for reads and writes, and includes the pointer and status registers.
- R6: When pointer bits 6:0 are zero, a read of offset 0x00 returns 0x00 and a write to offset 0x00 has no effect.
- R7: Read data updates on the first clock edge at which the read strobe is high and holds at all other edges. A read and a write to the same location in one cycle return the value held before the write.
- R8: A write lands at the edge that samples it. The pointer output shows a new pointer value after that edge. A status write moves direct accesses to the new bank starting with the next cycle.
- R9: Stepping the pointer by one between indirect writes fills consecutive locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 7 | Offset within the selected bank; 0x00 is the indirect location |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ptr | output | 8 | Current pointer register value |

## Verification
Every result in this block is due exactly one rising edge after its stimulus. That covers read data after a read strobe, the pointer output after a pointer write, and the bank move after a status write. The bench drives each operation on a falling edge and compares both outputs with its reference model on the next falling edge, after the single register stage has settled. Same-cycle read-and-write, bank changes and pointer-self cases are each placed so that the following operation observes the resulting state.

// File: rtl/bankreg_pkg.sv
// Package: shared target classes and fixed control-region offsets for the
// two-bank register file. Assumes a 7-bit offset and an 8-bit pointer.
package bankreg_pkg;

    // What an access finally lands on after address resolution.
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,   // reads 0, write dropped
        TGT_STAT = 2'd1,   // status register
        TGT_PTR  = 2'd2,   // pointer register
        TGT_GPR  = 2'd3    // general-purpose byte
    } tgt_e;

    localparam int OFS_IND  = 0;  // virtual indirect location
    localparam int OFS_PTR  = 1;  // pointer register, both banks
    localparam int OFS_STAT = 2;  // status register, both banks
    localparam int BANK_BIT = 5;  // status bit that selects the bank

endpackage

// File: rtl/bankreg_resolve.sv
// Module: bankreg_resolve
// Turns a direct offset plus the current bank bit, or the pointer when the
// offset is the indirect location, into a target class, a bank and a
// general-purpose index. Purely combinational.
// Assumes DATA_W == ADDR_W + 1 (pointer top bit is the bank).
module bankreg_resolve
    import bankreg_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int SFR_COUNT = 12,
    parameter int BANK_SPAN = 80,
    localparam int GPR_DEPTH = BANK_SPAN - SFR_COUNT,
    localparam int GIDX_W    = $clog2(GPR_DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              bank_sel,
    input  logic [DATA_W-1:0] ptr_val,
    output tgt_e              tgt,
    output logic              tgt_bank,
    output logic [GIDX_W-1:0] gpr_idx
);

    logic [ADDR_W-1:0] eff_ofs;
    logic [ADDR_W-1:0] rel_ofs;

    // Pick effective bank and offset: pointer for indirect, else direct.
    always_comb begin
        if (addr == ADDR_W'(OFS_IND)) begin
            eff_ofs  = ptr_val[ADDR_W-1:0];
            tgt_bank = ptr_val[DATA_W-1];
        end else begin
            eff_ofs  = addr;
            tgt_bank = bank_sel;
        end
    end

    // Classify the effective offset into a target.
    always_comb begin
        rel_ofs = eff_ofs - ADDR_W'(SFR_COUNT);
        gpr_idx = rel_ofs[GIDX_W-1:0];
        if (eff_ofs == ADDR_W'(OFS_STAT))
            tgt = TGT_STAT;
        else if (eff_ofs == ADDR_W'(OFS_PTR))
            tgt = TGT_PTR;
        else if (eff_ofs < ADDR_W'(SFR_COUNT))
            tgt = TGT_NONE;             // indirect self-reference and spare control slots
        else if (eff_ofs < ADDR_W'(BANK_SPAN))
            tgt = TGT_GPR;
        else
            tgt = TGT_NONE;             // beyond the implemented span
    end

endmodule

// File: rtl/bankreg_ctl.sv
// Module: bankreg_ctl
// Holds the status and pointer registers shared by both banks.
// Assumes at most one of the two write enables is high in a cycle.
module bankreg_ctl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic              wr_ptr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] ptr_q
);

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_q <= '0;
        else if (wr_stat) stat_q <= wdata;
    end

    // Pointer register update.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (wr_ptr) ptr_q <= wdata;
    end

endmodule

// File: rtl/bankreg_gpr.sv
// Module: bankreg_gpr
// One bank of general-purpose bytes: synchronous write, asynchronous read.
// An index at or above DEPTH reads zero and does not write.
module bankreg_gpr #(
    parameter int DEPTH  = 68,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              idx_ok;

    // Guard against indexes past the array end.
    assign idx_ok = 32'(idx) < DEPTH;

    // Clear on reset, store on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && idx_ok) begin
            mem[idx] <= wdata;
        end
    end

    // Combinational read port.
    assign rdata = idx_ok ? mem[idx] : '0;

endmodule

// File: rtl/bankreg_file.sv
// Module: bankreg_file (top)
// Two-bank byte register file with a pointer-driven indirect location.
// Read data is registered one edge after rd_en; writes land at the edge.
// Assumes a single bank-select bit in status, hence exactly two banks.
module bankreg_file
    import bankreg_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int SFR_COUNT = 12,
    parameter int BANK_SPAN = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ptr
);

    localparam int NUM_BANKS = 2;
    localparam int GPR_DEPTH = BANK_SPAN - SFR_COUNT;
    localparam int GIDX_W    = $clog2(GPR_DEPTH);

    tgt_e              tgt;
    logic              tgt_bank;
    logic [GIDX_W-1:0] gpr_idx;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] ptr_q;
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];
    logic [DATA_W-1:0] rd_val;

    bankreg_resolve #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SFR_COUNT(SFR_COUNT),
        .BANK_SPAN(BANK_SPAN)
    ) u_resolve (
        .addr    (addr),
        .bank_sel(stat_q[BANK_BIT]),
        .ptr_val (ptr_q),
        .tgt     (tgt),
        .tgt_bank(tgt_bank),
        .gpr_idx (gpr_idx)
    );

    bankreg_ctl #(.DATA_W(DATA_W)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stat(wr_en && (tgt == TGT_STAT)),
        .wr_ptr (wr_en && (tgt == TGT_PTR)),
        .wdata  (wdata),
        .stat_q (stat_q),
        .ptr_q  (ptr_q)
    );

    // One storage bank per value of the bank-select bit.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bankreg_gpr #(.DEPTH(GPR_DEPTH), .DATA_W(DATA_W)) u_gpr (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (wr_en && (tgt == TGT_GPR) && (tgt_bank == 1'(b))),
            .idx  (gpr_idx),
            .wdata(wdata),
            .rdata(bank_rd[b])
        );
    end

    // Select the byte the resolved target presents.
    always_comb begin
        case (tgt)
            TGT_STAT: rd_val = stat_q;
            TGT_PTR:  rd_val = ptr_q;
            TGT_GPR:  rd_val = bank_rd[tgt_bank];
            default:  rd_val = '0;
        endcase
    end

    // Capture read data on the read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_val;
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/bankreg_chk.sv
// Module: bankreg_chk
// Port-level temporal checks for bankreg_file, attached by bind below.
module bankreg_chk #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] ptr
);

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R6
    ind_self_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == '0 && ptr[ADDR_W-1:0] == '0) |=> rdata == '0);

    // R4
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr >= 7'h50 || (addr >= 7'h03 && addr <= 7'h0B))) |=> rdata == '0);

    // R8
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 7'h01) |=> ptr == $past(wdata));

    // R8
    ptr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ptr));

endmodule

bind bankreg_file bankreg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .rd_en(rd_en),
    .wr_en(wr_en),
    .addr (addr),
    .wdata(wdata),
    .rdata(rdata),
    .ptr  (ptr)
);

// File: tb/sim_bankreg_file.sv
`timescale 1ns/1ps
module sim_bankreg_file;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rd_en, wr_en;
    logic [6:0] addr;
    logic [7:0] wdata;
    wire  [7:0] rdata;
    wire  [7:0] ptr;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string cur_req = "R1";

    // Behavioural reference: flat 256-byte space indexed by {bank, offset}.
    int unsigned m_mem [256];
    int unsigned m_stat, m_ptr, m_rd;

    always #2.5 clk = ~clk;

    bankreg_file u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ptr(ptr)
    );

    function automatic int unsigned eff_of(input int unsigned a);
        if (a == 0) return m_ptr;
        return ((m_stat >> 5) & 1) * 128 + a;
    endfunction

    function automatic int unsigned read_of(input int unsigned f);
        int unsigned o = f % 128;
        if (o == 0) return 0;
        if (o == 1) return m_ptr;
        if (o == 2) return m_stat;
        if (o < 12 || o > 79) return 0;
        return m_mem[f];
    endfunction

    task automatic write_to(input int unsigned f, input int unsigned d);
        int unsigned o = f % 128;
        if (o == 1) m_ptr = d;
        else if (o == 2) m_stat = d;
        else if (o >= 12 && o <= 79) m_mem[f] = d;
    endtask

    // Reference model steps on every rising edge from pre-edge inputs.
    always @(posedge clk) begin : model
        int unsigned f;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) m_mem[i] = 0;
            m_stat = 0; m_ptr = 0; m_rd = 0;
        end else begin
            f = eff_of(addr);
            if (rd_en) m_rd = read_of(f);
            if (wr_en) write_to(f, wdata);
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one operation at a falling edge, compare at the next falling edge.
    task automatic op(input logic r, input logic w, input logic [6:0] a, input logic [7:0] d);
        rd_en = r; wr_en = w; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        rd_en = 0; wr_en = 0;
        chk(cur_req, rdata, m_rd[7:0]);
        chk(cur_req, ptr, m_ptr[7:0]);
    endtask

    task automatic rd(input string req, input logic [6:0] a, input logic [7:0] exp);
        op(1, 0, a, 8'h00);
        chk(req, rdata, exp);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        op(0, 1, a, d);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; rd_en = 0; wr_en = 0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1", rdata, 8'h00);
        chk("R1", ptr, 8'h00);
        rd("R1", 7'h20, 8'h00);
        rd("R1", 7'h02, 8'h00);

        cur_req = "R2";
        wr(7'h0C, 8'hA1);
        wr(7'h4F, 8'hB2);
        rd("R2", 7'h0C, 8'hA1);
        rd("R2", 7'h4F, 8'hB2);
        wr(7'h02, 8'h20);                 // select bank 1
        rd("R2", 7'h0C, 8'h00);
        wr(7'h0C, 8'hC3);
        rd("R2", 7'h0C, 8'hC3);

        cur_req = "R3";
        rd("R3", 7'h02, 8'h20);
        wr(7'h01, 8'h5A);
        chk("R8", ptr, 8'h5A);
        wr(7'h02, 8'h00);                 // back to bank 0
        rd("R3", 7'h01, 8'h5A);
        rd("R2", 7'h0C, 8'hA1);

        cur_req = "R4";
        wr(7'h50, 8'hFF); rd("R4", 7'h50, 8'h00);
        wr(7'h7F, 8'h11); rd("R4", 7'h7F, 8'h00);
        wr(7'h05, 8'h22); rd("R4", 7'h05, 8'h00);
        wr(7'h0B, 8'h33); rd("R4", 7'h0B, 8'h00);

        cur_req = "R5";
        wr(7'h01, 8'h0C);
        rd("R5", 7'h00, 8'hA1);
        wr(7'h00, 8'h99);
        rd("R5", 7'h0C, 8'h99);
        wr(7'h01, 8'h8C);
        rd("R5", 7'h00, 8'hC3);
        wr(7'h01, 8'h82);
        rd("R5", 7'h00, 8'h00);
        wr(7'h01, 8'h01);
        wr(7'h00, 8'h30);
        chk("R5", ptr, 8'h30);

        cur_req = "R9";
        wr(7'h01, 8'h20);
        for (int i = 0; i < 16; i++) begin
            wr(7'h00, 8'(8'h40 + i));
            wr(7'h01, 8'(8'h21 + i));
        end
        for (int i = 0; i < 16; i++) rd("R9", 7'(7'h20 + i), 8'(8'h40 + i));

        cur_req = "R6";
        wr(7'h01, 8'h00);
        rd("R6", 7'h00, 8'h00);
        wr(7'h00, 8'h77);
        chk("R6", ptr, 8'h00);
        rd("R6", 7'h02, 8'h00);
        rd("R6", 7'h0C, 8'h99);
        wr(7'h01, 8'h80);
        rd("R6", 7'h00, 8'h00);
        wr(7'h00, 8'h66);
        chk("R6", ptr, 8'h80);

        cur_req = "R7";
        wr(7'h30, 8'h12);
        op(1, 1, 7'h30, 8'h34);
        chk("R7", rdata, 8'h12);
        op(0, 0, 7'h30, 8'h00);
        chk("R7", rdata, 8'h12);
        rd("R7", 7'h30, 8'h34);

        cur_req = "R8";
        wr(7'h02, 8'h20);
        rd("R8", 7'h0C, 8'hC3);
        wr(7'h02, 8'h00);
        rd("R8", 7'h0C, 8'h99);

        cur_req = "R7 random";
        for (int i = 0; i < 3000; i++) begin
            int unsigned sel = $urandom_range(0, 9);
            logic [6:0] a;
            if (sel < 2)      a = 7'h00;
            else if (sel < 4) a = 7'($urandom_range(1, 2));
            else              a = 7'($urandom_range(0, 127));
            op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, 8'($urandom_range(0, 255)));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule